// File: doc/BRIEF.md
# Slot-Rotated Interrupt Router

This block gathers level interrupt requests from a row of device slots. Each slot has four request pins, A to D, numbered 0 to 3. Each pin is rotated by its slot number onto one of four shared request lines, so that devices in neighbouring slots spread their pin A requests across different lines. A shared line is high whenever any device pin mapped onto it is high.

Four steering bytes, one for each shared line, select which of the sixteen interrupt-controller inputs that shared line drives. A steering value of 16 or more leaves the shared line unconnected. A two-byte trigger-mode register holds one level/edge flag for each controller input and presents it to the controller. Firmware reads and writes all six bytes through a simple byte-wide register port.

Top module: `intx_router`

## Requirements
- R1: Pin p (A=0 … D=3) of slot s, carried on `dev_irq_i` bit 4*s+p, drives shared line (p + s) mod 4.
- R2: A shared line is the OR of every device pin mapped onto it; it stays high until the last of those pins falls.
- R3: Steering byte n sits at register address n (n = 0..3). A value v below 16 drives controller line v[3:0] from shared line n. Any value of 16 or above drives no controller line.
- R4: After reset, all four steering bytes read 0x80, both trigger-mode bytes read 0x00, `ctrl_irq_o` is 0 and `trig_level_o` is 0.
- R5: When two or more shared lines steer to the same controller line, that line is the OR of those shared lines.
- R6: A change on `dev_irq_i` reaches `ctrl_irq_o` on the first rising clock edge after the change, and not before.
- R7: A steering write is applied on the same clock edge that stores it. A shared line moved to a new target drops at the old target and rises at the new one on that edge.
- R8: Trigger-mode byte 0 at address 4 holds the flags for controller lines 0–7, and byte 1 at address 5 holds lines 8–15. Bit i of the byte maps to line 8*byte+i. The flags appear on `trig_level_o` and read back unchanged.
- R9: Addresses 6 and 7 read 0x00. Writes to them change no steering or trigger-mode byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dev_irq_i | input | NUM_SLOTS*4 | Device request levels, slot-major, four pins per slot |
| reg_we_i | input | 1 | Register write strobe, one byte per cycle |
| reg_addr_i | input | 3 | Register byte address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i`, combinational |
| ctrl_irq_o | output | 16 | Registered levels to the interrupt controller |
| trig_level_o | output | 16 | Trigger-mode flags, one per controller line |

## Verification
The assertions assume that `dev_irq_i` and the register port are held steady across each rising edge. They also assume that each write strobe lasts exactly one cycle with a known address. The bench changes every input only on falling edges and drops the strobe after a single edge. Samples are taken half a period away from the edge that updates the outputs. Pin patterns stay inside the configured slot count, so every rotation lands on a real shared line.

// File: rtl/intx_router_pkg.sv
package intx_router_pkg;
  localparam int NUM_PINS   = 4;
  localparam int NUM_SHARED = 4;
  localparam int NUM_CTRL   = 16;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 3;
  localparam int TRIG_BYTES = NUM_CTRL / BYTE_W;
  localparam int TRIG_BASE  = NUM_SHARED;
  localparam logic [BYTE_W-1:0] STEER_RST = 8'h80;

  typedef logic [BYTE_W-1:0] steer_t;
  typedef steer_t [NUM_SHARED-1:0] steer_arr_t;
endpackage

// File: rtl/intx_swizzle.sv
module intx_swizzle
  import intx_router_pkg::*;
#(
  parameter int NUM_SLOTS = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_SLOTS*NUM_PINS-1:0] dev_irq_i,
  output logic [NUM_SHARED-1:0]         shared_o
);
  always_comb begin
    shared_o = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        logic [1:0] sel;
        sel = 2'((p + s) % NUM_SHARED);
        if (dev_irq_i[s*NUM_PINS+p]) shared_o[sel] = 1'b1;
      end
    end
  end

  // no request anywhere means no shared line may be high
  assert_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_irq_i == '0) |-> (shared_o == '0));

  // slot 0 pin A always lands on shared line 0
  assert_slot0_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_irq_i[0] |-> shared_o[0]);
endmodule

// File: rtl/intx_steer_regs.sv
module intx_steer_regs
  import intx_router_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  output logic [BYTE_W-1:0]   rdata_o,
  output steer_arr_t          steer_next_o,
  output logic [NUM_CTRL-1:0] trig_o
);
  steer_arr_t steer_q;
  logic [TRIG_BYTES-1:0][BYTE_W-1:0] trig_q;

  // next-state view feeds the steering stage so writes apply on their own edge
  always_comb begin
    steer_next_o = steer_q;
    for (int n = 0; n < NUM_SHARED; n++)
      if (we_i && addr_i == ADDR_W'(n)) steer_next_o[n] = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      steer_q <= {NUM_SHARED{STEER_RST}};
      trig_q  <= '0;
    end else begin
      steer_q <= steer_next_o;
      for (int b = 0; b < TRIG_BYTES; b++)
        if (we_i && addr_i == ADDR_W'(TRIG_BASE + b)) trig_q[b] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int n = 0; n < NUM_SHARED; n++)
      if (addr_i == ADDR_W'(n)) rdata_o = steer_q[n];
    for (int b = 0; b < TRIG_BYTES; b++)
      if (addr_i == ADDR_W'(TRIG_BASE + b)) rdata_o = trig_q[b];
  end

  assign trig_o = trig_q;

  assert_unmapped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i >= ADDR_W'(TRIG_BASE + TRIG_BYTES)) |=> ($stable(steer_q) && $stable(trig_q)));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(steer_q) && $stable(trig_q)));
endmodule

// File: rtl/intx_steer.sv
module intx_steer
  import intx_router_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_SHARED-1:0] shared_i,
  input  steer_arr_t            steer_i,
  output logic [NUM_CTRL-1:0]   ctrl_o
);
  localparam int CTRL_W = $clog2(NUM_CTRL);

  logic [NUM_CTRL-1:0] ctrl_d, ctrl_q;

  for (genvar k = 0; k < NUM_CTRL; k++) begin : g_line
    always_comb begin
      ctrl_d[k] = 1'b0;
      for (int n = 0; n < NUM_SHARED; n++)
        if (shared_i[n] && steer_i[n] < BYTE_W'(NUM_CTRL) &&
            steer_i[n][CTRL_W-1:0] == CTRL_W'(k))
          ctrl_d[k] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  assert_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shared_i == '0) |=> (ctrl_q == '0));

  assert_fanout_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(ctrl_q) <= NUM_SHARED));

  assert_unrouted_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steer_i[0] >= BYTE_W'(NUM_CTRL) && steer_i[1] >= BYTE_W'(NUM_CTRL) &&
     steer_i[2] >= BYTE_W'(NUM_CTRL) && steer_i[3] >= BYTE_W'(NUM_CTRL)) |=> (ctrl_q == '0));
endmodule

// File: rtl/intx_router.sv
module intx_router
  import intx_router_pkg::*;
#(
  parameter int NUM_SLOTS = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_SLOTS*NUM_PINS-1:0] dev_irq_i,
  input  logic                          reg_we_i,
  input  logic [ADDR_W-1:0]             reg_addr_i,
  input  logic [BYTE_W-1:0]             reg_wdata_i,
  output logic [BYTE_W-1:0]             reg_rdata_o,
  output logic [NUM_CTRL-1:0]           ctrl_irq_o,
  output logic [NUM_CTRL-1:0]           trig_level_o
);
  logic [NUM_SHARED-1:0] shared;
  steer_arr_t            steer_next;

  intx_swizzle #(.NUM_SLOTS(NUM_SLOTS)) u_swizzle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dev_irq_i (dev_irq_i),
    .shared_o  (shared)
  );

  intx_steer_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (reg_we_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .rdata_o      (reg_rdata_o),
    .steer_next_o (steer_next),
    .trig_o       (trig_level_o)
  );

  intx_steer u_steer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .shared_i (shared),
    .steer_i  (steer_next),
    .ctrl_o   (ctrl_irq_o)
  );
endmodule

// File: tb/tb_intx_router.sv
module tb_intx_router;
  localparam int SLOTS = 32;

  logic              clk = 0;
  logic              rst_n = 0;
  logic [SLOTS*4-1:0] dev = '0;
  logic              we = 0;
  logic [2:0]        addr = '0;
  logic [7:0]        wdata = '0;
  logic [7:0]        rdata;
  logic [15:0]       ctrl, trig;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  intx_router #(.NUM_SLOTS(SLOTS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .dev_irq_i(dev),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .ctrl_irq_o(ctrl), .trig_level_o(trig));

  // {slot, pin, expected ctrl} with steering 0->3, 1->5, 2->9, 3->14
  localparam logic [25:0] VEC [10] = '{
    {8'd0,  2'd0, 16'h0008}, {8'd0,  2'd3, 16'h4000},
    {8'd1,  2'd0, 16'h0020}, {8'd1,  2'd3, 16'h0008},
    {8'd2,  2'd1, 16'h4000}, {8'd5,  2'd2, 16'h4000},
    {8'd7,  2'd1, 16'h0008}, {8'd31, 2'd3, 16'h0200},
    {8'd13, 2'd2, 16'h4000}, {8'd30, 2'd0, 16'h0200}};

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    chk(req, {8'h0, rdata}, {8'h0, exp});
  endtask

  task automatic settle; @(negedge clk); @(negedge clk); endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3 rst_n = 0;
    #20 rst_n = 1;
    // R4 reset values
    for (int n = 0; n < 4; n++) rd_chk("R4", 3'(n), 8'h80);
    rd_chk("R4", 3'd4, 8'h00);
    rd_chk("R4", 3'd5, 8'h00);
    chk("R4", ctrl, 16'h0);
    chk("R4", trig, 16'h0);

    // R3 unrouted at reset value 0x80
    @(negedge clk); dev[0] = 1; settle();
    chk("R3", ctrl, 16'h0);
    @(negedge clk); dev = '0;

    wr(3'd0, 8'd3); wr(3'd1, 8'd5); wr(3'd2, 8'd9); wr(3'd3, 8'd14);
    rd_chk("R3", 3'd3, 8'd14);

    // R1 rotation table walk
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); dev = '0; dev[4*VEC[i][25:18] + VEC[i][17:16]] = 1'b1;
      settle();
      chk("R1", ctrl, VEC[i][15:0]);
    end
    @(negedge clk); dev = '0; settle();

    // R6 latency: unchanged before the edge, updated after it
    @(negedge clk); dev[4] = 1; #1;
    chk("R6", ctrl, 16'h0);
    @(posedge clk); #1;
    chk("R6", ctrl, 16'h0020);
    @(negedge clk); dev = '0; settle();

    // R2 OR of two pins on shared line 0 (slot0 A, slot1 D)
    @(negedge clk); dev[0] = 1; dev[7] = 1; settle();
    chk("R2", ctrl, 16'h0008);
    @(negedge clk); dev[0] = 0; settle();
    chk("R2", ctrl, 16'h0008);
    @(negedge clk); dev[7] = 0; settle();
    chk("R2", ctrl, 16'h0000);

    // R5 two shared lines onto controller line 7
    wr(3'd0, 8'd7); wr(3'd1, 8'd7);
    @(negedge clk); dev[1] = 1; settle();
    chk("R5", ctrl, 16'h0080);
    @(negedge clk); dev[0] = 1; dev[1] = 0; settle();
    chk("R5", ctrl, 16'h0080);

    // R7 move shared line 0 from 7 to 10 while held
    @(negedge clk); we = 1; addr = 3'd0; wdata = 8'd10; #1;
    chk("R7", ctrl, 16'h0080);
    @(posedge clk); #1;
    chk("R7", ctrl, 16'h0400);
    @(negedge clk); we = 0;
    // R3 boundaries 15 and 16
    wr(3'd0, 8'd15); #1;
    chk("R3", ctrl, 16'h8000);
    wr(3'd0, 8'd16); #1;
    chk("R3", ctrl, 16'h0000);
    @(negedge clk); dev = '0;

    // R8 trigger mode bytes
    wr(3'd4, 8'h21); wr(3'd5, 8'h0A);
    #1 chk("R8", trig, 16'h0A21);
    rd_chk("R8", 3'd5, 8'h0A);

    // R9 unmapped address
    wr(3'd6, 8'hFF); wr(3'd7, 8'h5A);
    rd_chk("R9", 3'd6, 8'h00);
    rd_chk("R9", 3'd7, 8'h00);
    rd_chk("R9", 3'd0, 8'd16);
    rd_chk("R9", 3'd4, 8'h21);
    chk("R9", trig, 16'h0A21);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule